// File: doc/BRIEF.md
# Ling Pseudo-Carry Adder

This block adds two unsigned or two's-complement operands of a parameterised width together with a single carry-in. It is purely combinational. It returns the truncated sum, the carry out of the top bit and a signed-overflow flag. Internally it never builds ordinary carries. Each bit produces a generate term (AND of the operand bits) and a transmit term (OR of the operand bits). Pseudo-carries then travel through 4-bit lookahead groups, each group seeded by the pseudo-carry of the group below. The real carry into any bit is rebuilt only at the sum stage, as the pseudo-carry of that bit ANDed with the transmit term of the bit beneath it.

The width must be a multiple of four. The bottom of the chain takes the carry-in as its starting pseudo-carry. The block is meant to sit inside a wider datapath stage wherever a single-cycle add with overflow detection is needed.

Top module: `ling_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of opA + opB + carryIn for every operand pair and both carry-in values (WIDTH = 16 by default).
- R2: `carryOut` equals bit WIDTH of the full-precision result opA + opB + carryIn.
- R3: `overflow` is 1 exactly when opA and opB have equal most-significant bits and `sum` has a different most-significant bit.
- R4: When opB is the bitwise complement of opA and carryIn is 1, the carry travels through every group: `sum` is all zeros and `carryOut` is 1. With carryIn 0 the same operands give an all-ones `sum` and `carryOut` 0.
- R5: When both operands have their most-significant bit set, `carryOut` is 1 whatever the lower bits and carry-in are.
- R6: A bit position where both operand bits are 0 stops any carry. Every sum bit above it up to the next generating position equals the XOR of the operand bits, even with carryIn 1.
- R7: The outputs follow the inputs with no clock and no stored state. With all inputs 0 the outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Truncated sum |
| carryOut | output | 1 | Carry out of the top bit |
| overflow | output | 1 | Two's-complement overflow |

## Verification
The case hardest to reach is a carry that must cross every group boundary in one go: the pseudo-carry chain has to stay transmitting from the carry-in to the top bit. Random operands almost never produce this. The stimulus therefore applies operand pairs that are exact complements of each other with both carry-in values. It also applies pairs with a deliberate zero-zero bit that must block a long run of transmitting bits, and pairs that sit on the signed boundary to bring out overflow. Ten thousand random vectors then cover the general mix of generate, transmit and kill patterns.

// File: rtl/ling_pkg.sv
package ling_pkg;
  localparam int GROUP_BITS = 4;

  typedef struct packed {
    logic gen;
    logic tx;
    logic prop;
  } bitSig_t;
endpackage

// File: rtl/ling_bit_cells.sv
module ling_bit_cells
  import ling_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic    [WIDTH-1:0] opA,
  input  logic    [WIDTH-1:0] opB,
  output bitSig_t [WIDTH-1:0] cells
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign cells[i].gen  = opA[i] & opB[i];
    assign cells[i].tx   = opA[i] | opB[i];
    assign cells[i].prop = opA[i] ^ opB[i];
  end
endmodule

// File: rtl/ling_group.sv
module ling_group
  import ling_pkg::*;
(
  input  bitSig_t [GROUP_BITS-1:0] cells,
  input  logic                     tPrev,
  input  logic                     hIn,
  output logic    [GROUP_BITS-1:0] hOut
);
  logic [GROUP_BITS-1:0] g, t;
  logic seed;

  always_comb begin
    for (int k = 0; k < GROUP_BITS; k++) begin
      g[k] = cells[k].gen;
      t[k] = cells[k].tx;
    end
    seed = tPrev & hIn;
    hOut[0] = g[0] | seed;
    hOut[1] = g[1] | g[0] | (t[0] & seed);
    hOut[2] = g[2] | g[1] | (t[1] & g[0]) | (t[1] & t[0] & seed);
    hOut[3] = g[3] | g[2] | (t[2] & g[1]) | (t[2] & t[1] & g[0])
            | (t[2] & t[1] & t[0] & seed);
  end

  // R5: generate at the top bit of a group forces the outgoing pseudo-carry
  always_comb begin
    if (g[3]) a_r5_gen_forces: assert (hOut[3]) else $error("group generate lost");
  end

  // R4: full transmission with a live pseudo-carry keeps every output high
  always_comb begin
    if (hIn && tPrev && (&t))
      a_r4_full_transmit: assert (&hOut) else $error("group transmit broken");
  end

  // R6: no incoming pseudo-carry and no generate leaves the group silent
  always_comb begin
    if (!hIn && (g == '0))
      a_r6_quiet_group: assert (hOut == '0) else $error("group spurious carry");
  end
endmodule

// File: rtl/ling_pseudo_chain.sv
module ling_pseudo_chain
  import ling_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  bitSig_t [WIDTH-1:0] cells,
  input  logic                carryIn,
  output logic    [WIDTH:0]   hChain
);
  localparam int NUM_GROUPS = WIDTH / GROUP_BITS;

  if (WIDTH % GROUP_BITS != 0) begin : g_bad_width
    $error("WIDTH must be a multiple of the group size");
  end

  assign hChain[0] = carryIn;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    localparam int BASE = k * GROUP_BITS;
    logic tBelow;
    if (k == 0) begin : g_first
      assign tBelow = 1'b1;
    end else begin : g_rest
      assign tBelow = cells[BASE-1].tx;
    end
    ling_group u_group (
      .cells (cells[BASE+GROUP_BITS-1:BASE]),
      .tPrev (tBelow),
      .hIn   (hChain[BASE]),
      .hOut  (hChain[BASE+GROUP_BITS:BASE+1])
    );
  end
endmodule

// File: rtl/ling_sum.sv
module ling_sum
  import ling_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  bitSig_t [WIDTH-1:0] cells,
  input  logic    [WIDTH:0]   hChain,
  output logic    [WIDTH-1:0] sum,
  output logic                carryOut,
  output logic                overflow
);
  logic [WIDTH-1:0] carryIntoBit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign carryIntoBit[i] = hChain[0];
    end else begin : g_upper
      assign carryIntoBit[i] = hChain[i] & cells[i-1].tx;
      // R6: a killed position below blocks any carry into this bit
      always_comb begin
        if (!cells[i-1].tx)
          a_r6_kill_blocks: assert (sum[i] == cells[i].prop) else $error("kill leaked");
      end
    end
    assign sum[i] = cells[i].prop ^ carryIntoBit[i];
  end

  assign carryOut = hChain[WIDTH] & cells[WIDTH-1].tx;
  assign overflow = carryOut ^ carryIntoBit[WIDTH-1];
endmodule

// File: rtl/ling_adder.sv
module ling_adder
  import ling_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             overflow
);
  bitSig_t [WIDTH-1:0] cells;
  logic    [WIDTH:0]   hChain;

  ling_bit_cells #(.WIDTH(WIDTH)) u_cells (
    .opA   (opA),
    .opB   (opB),
    .cells (cells)
  );

  ling_pseudo_chain #(.WIDTH(WIDTH)) u_chain (
    .cells   (cells),
    .carryIn (carryIn),
    .hChain  (hChain)
  );

  ling_sum #(.WIDTH(WIDTH)) u_sum (
    .cells    (cells),
    .hChain   (hChain),
    .sum      (sum),
    .carryOut (carryOut),
    .overflow (overflow)
  );

  // R3: overflow flag agrees with the operand/result sign rule
  always_comb begin
    a_r3_sign_rule: assert (overflow ==
      ((opA[WIDTH-1] == opB[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1])))
      else $error("overflow flag wrong");
  end

  // R5: both top bits set always produce a carry-out
  always_comb begin
    if (opA[WIDTH-1] && opB[WIDTH-1])
      a_r5_top_generate: assert (carryOut) else $error("top generate lost");
  end
endmodule

// File: tb/ling_adder_bench.sv
module ling_adder_bench;
  localparam int W = 16;
  localparam int NUM_RANDOM = 10000;
  localparam int WATCHDOG = 200000;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    string        tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [W-1:0] sum;
  logic carryOut, overflow;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit driverDone = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ling_adder #(.WIDTH(W)) u_ling_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut), .overflow(overflow)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic cin, input string tag);
    item_t it;
    @(negedge clk);
    opA = a; opB = b; carryIn = cin;
    it.a = a; it.b = b; it.cin = cin; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: pops one expected item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        logic [W:0] full;
        logic expOvf;
        it = expQ.pop_front();
        full = {1'b0, it.a} + {1'b0, it.b} + {{W{1'b0}}, it.cin};
        expOvf = (it.a[W-1] == it.b[W-1]) && (full[W-1] != it.a[W-1]);
        compared++;
        if (sum !== full[W-1:0]) begin
          mismatched++;
          $display("FAIL R1 [%s] sum actual %h expected %h", it.tag, sum, full[W-1:0]);
        end else if (carryOut !== full[W]) begin
          mismatched++;
          $display("FAIL R2 [%s] carryOut actual %b expected %b", it.tag, carryOut, full[W]);
        end else if (overflow !== expOvf) begin
          mismatched++;
          $display("FAIL R3 [%s] overflow actual %b expected %b", it.tag, overflow, expOvf);
        end
      end else if (driverDone) begin
        finish_run();
      end
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R7: quiescent state
    drive('0, '0, 1'b0, "R7 all zero");
    // R1/R2: all zeros and all ones, both carry-in values
    drive('0, '0, 1'b1, "R1 zero plus cin");
    drive('1, '1, 1'b0, "R2 ones cin0");
    drive('1, '1, 1'b1, "R2 ones cin1");
    // R1: alternating patterns
    drive({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b0, "R1 alt cin0");
    drive({(W/2){2'b01}}, {(W/2){2'b10}}, 1'b1, "R4 alt cin1");
    drive({(W/2){2'b10}}, {(W/2){2'b10}}, 1'b0, "R1 alt same");
    drive({(W/2){2'b01}}, {(W/2){2'b01}}, 1'b1, "R1 alt same cin1");
    // R4: complement pairs carry through every group
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] x;
      x = W'($urandom());
      drive(x, ~x, 1'b1, "R4 complement cin1");
      drive(x, ~x, 1'b0, "R4 complement cin0");
    end
    // R3: signed boundary
    drive({1'b0, {(W-1){1'b1}}}, W'(1), 1'b0, "R3 max plus one");
    drive({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R3 min plus min");
    drive({1'b1, {(W-1){1'b0}}}, '1, 1'b0, "R3 min minus one");
    drive({1'b0, {(W-1){1'b1}}}, '0, 1'b1, "R3 max via cin");
    // R5: top-bit generate with varied lower bits
    for (int k = 0; k < 8; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom()) | {1'b1, {(W-1){1'b0}}};
      y = W'($urandom()) | {1'b1, {(W-1){1'b0}}};
      drive(x, y, k[0], "R5 top generate");
    end
    // R6: a zero-zero bit below a long transmit run
    for (int z = 0; z < W; z++) begin
      logic [W-1:0] a, b;
      a = '1; b = '1;
      a[z] = 1'b0; b[z] = 1'b0;
      a = a & {W{1'b1}};
      b = '0; b[z] = 1'b0;
      drive(a, b, 1'b1, "R6 kill position");
    end
    // R1: random operands
    for (int n = 0; n < NUM_RANDOM; n++) begin
      drive(W'($urandom()), W'($urandom()), 1'($urandom()), "R1 random");
    end
    driverDone = 1'b1;
  end
endmodule